// File: doc/BRIEF.md
# Winner-Take-All Spiking Neuron Layer

This block is the output layer of a small spiking network. A group of integrate-and-fire neurons is fully connected to a binary input image through single-bit synapse weights. The image arrives as a stream of fixed-width pixel words. For each word the caller presents the pixels together with that word's weight row for every neuron. Each neuron adds to its membrane potential the number of pixels that are 1 and whose synapse is ON. The additions saturate, and a neuron in its refractory period does not integrate.

After the last word of a step, the neurons take part in a competition. Of the eligible neurons whose potential has reached the programmable threshold, only one fires: the one with the highest potential, with ties going to the lower index. The winner is announced with a one-cycle pulse, all potentials are cleared, and the winner becomes refractory for a programmable number of steps.

After a spike, the block runs a learning pass over the same word sequence. In that pass it turns the winner's pixel activity into potentiation and depression masks, using one of four polarity modes. Potentials that stay below the threshold are kept into the next step.

Top module: `wta_if_layer`

## Requirements
- R1: After reset, busy_o, spike_valid_o and upd_valid_o are 0 and word_idx_o is 0.
- R2: A step starts on start_i while idle and accepts N_WORDS words with pix_valid_i. word_idx_o gives the index of the word expected next. Each accepted word adds popcount(pix_i AND the neuron's weight row) to that neuron's potential, where neuron k's row is weight_i[k*WORD_W +: WORD_W]. Potentials carry over between steps until a spike occurs.
- R3: Two cycles after the clock edge that accepts the last word, spike_valid_o is high for exactly one cycle if at least one eligible neuron has potential >= threshold, and winner_o gives that neuron. winner_o holds its value until the next spike.
- R4: Among the eligible neurons at or above the threshold, the one with the highest potential wins. When potentials are equal, the lowest index wins.
- R5: A spike clears the potentials of all neurons to zero.
- R6: A neuron that fires is excluded from integration and from the competition for the next refr_len_i steps.
- R7: thresh_we_i loads thresh_i into the threshold only while idle. A write while busy has no effect.
- R8: After a spike, a learning pass accepts N_WORDS words, and upd_valid_o follows pix_valid_i. With mode_i 0 (Hebbian), upd_pot_o = pix_i and upd_dep_o = 0. With mode 1 (anti-Hebbian), upd_pot_o = 0 and upd_dep_o = pix_i. With mode 2 (timing-dependent), upd_pot_o = pix_i & ~late_i and upd_dep_o = pix_i & late_i, where late_i marks inputs that spiked after the output spike. Mode 3 swaps the two masks of mode 2. The block is idle in the cycle after the last learning word.
- R9: If no neuron fires, no learning pass follows and the block is idle in the cycle after the decision.
- R10: Potentials saturate at 2^POT_W-1 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thresh_we_i | input | 1 | Threshold write strobe (applied only while idle) |
| thresh_i | input | POT_W | Threshold value to load |
| refr_len_i | input | REFR_W | Refractory length, in steps |
| mode_i | input | 2 | Learning polarity mode |
| start_i | input | 1 | Begin an evaluation step |
| pix_valid_i | input | 1 | Pixel word valid |
| pix_i | input | WORD_W | Binary pixel word |
| weight_i | input | N_NEURONS*WORD_W | Weight rows of all neurons for the current word |
| late_i | input | WORD_W | Per-input flag: spike came after the output spike |
| busy_o | output | 1 | Step or learning pass in progress |
| word_idx_o | output | WIDX_W | Index of the next expected word |
| spike_valid_o | output | 1 | One-cycle spike pulse |
| winner_o | output | NIDX_W | Index of the most recent winner |
| upd_valid_o | output | 1 | Update masks valid |
| upd_pot_o | output | WORD_W | Potentiation request mask |
| upd_dep_o | output | WORD_W | Depression request mask |

## Verification
The bench uses the default size: nine neurons, 64-bit words, 64 words per step and a 13-bit potential. With these values, an all-ON neuron reaches 4096 in one step, so the overflow past 8191 is reachable in just two steps and the saturation rule can be checked directly. Each neuron's weight row is a run of low ones, which gives each neuron a known potential per step. This makes it possible to set up exact ties, sub-threshold carry-over and refractory hand-offs between neurons. Rotated, irregular pixel words with a fixed lateness mask are used to check the masks of all four learning modes word by word.

// File: rtl/wta_pkg.sv
package wta_pkg;
  typedef enum logic [1:0] {
    LM_HEBB      = 2'd0,
    LM_ANTI_HEBB = 2'd1,
    LM_STDP      = 2'd2,
    LM_ANTI_STDP = 2'd3
  } learn_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_INTEG, ST_DECIDE, ST_LEARN
  } step_state_e;
endpackage

// File: rtl/wta_neuron.sv
module wta_neuron #(
  parameter int WORD_W = 64,
  parameter int POT_W  = 13,
  parameter int REFR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_en_i,
  input  logic              clr_i,
  input  logic              fire_i,
  input  logic              step_done_i,
  input  logic [REFR_W-1:0] refr_len_i,
  input  logic [WORD_W-1:0] pix_i,
  input  logic [WORD_W-1:0] w_i,
  output logic [POT_W-1:0]  pot_o,
  output logic              elig_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int SUM_W = POT_W + 1;

  function automatic logic [CNT_W-1:0] popc(input logic [WORD_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < WORD_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  logic [POT_W-1:0]  pot_q;
  logic [REFR_W-1:0] refr_q;
  logic [SUM_W-1:0]  sum;

  assign elig_o = (refr_q == '0);
  assign sum    = {1'b0, pot_q} + SUM_W'(popc(pix_i & w_i));
  assign pot_o  = pot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pot_q <= '0;
    end else if (clr_i) begin
      pot_q <= '0;
    end else if (acc_en_i && elig_o) begin
      pot_q <= sum[POT_W] ? '1 : sum[POT_W-1:0];  // saturate
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) refr_q <= '0;
    else if (fire_i) refr_q <= refr_len_i;
    else if (step_done_i && refr_q != '0) refr_q <= refr_q - REFR_W'(1);
  end

  a_r10_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && !clr_i) |=> pot_q >= $past(pot_q));
  a_r6_refr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && !clr_i && refr_q != '0) |=> $stable(pot_q));
endmodule

// File: rtl/wta_arbiter.sv
module wta_arbiter #(
  parameter int N_NEURONS = 9,
  parameter int POT_W     = 13,
  localparam int NIDX_W   = $clog2(N_NEURONS)
) (
  input  logic [N_NEURONS-1:0][POT_W-1:0] pot_i,
  input  logic [N_NEURONS-1:0]            elig_i,
  input  logic [POT_W-1:0]                thr_i,
  output logic                            valid_o,
  output logic [NIDX_W-1:0]               idx_o
);
  logic [POT_W-1:0] best;

  // strict '>' keeps the lower index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int k = 0; k < N_NEURONS; k++) begin
      if (elig_i[k] && pot_i[k] >= thr_i && (!valid_o || pot_i[k] > best)) begin
        valid_o = 1'b1;
        idx_o   = NIDX_W'(k);
        best    = pot_i[k];
      end
    end
  end
endmodule

// File: rtl/wta_learn_map.sv
module wta_learn_map
  import wta_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic [1:0]        mode_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] pix_i,
  input  logic [WORD_W-1:0] late_i,
  output logic [WORD_W-1:0] pot_o,
  output logic [WORD_W-1:0] dep_o
);
  logic [WORD_W-1:0] early, late;

  assign early = pix_i & ~late_i;
  assign late  = pix_i & late_i;

  always_comb begin
    pot_o = '0;
    dep_o = '0;
    if (en_i) begin
      case (learn_mode_e'(mode_i))
        LM_HEBB:      pot_o = pix_i;
        LM_ANTI_HEBB: dep_o = pix_i;
        LM_STDP:      begin pot_o = early; dep_o = late;  end
        default:      begin pot_o = late;  dep_o = early; end
      endcase
    end
  end
endmodule

// File: rtl/wta_if_layer.sv
module wta_if_layer
  import wta_pkg::*;
#(
  parameter int N_NEURONS = 9,
  parameter int WORD_W    = 64,
  parameter int N_WORDS   = 64,
  parameter int POT_W     = 13,
  parameter int REFR_W    = 8,
  localparam int NIDX_W   = $clog2(N_NEURONS),
  localparam int WIDX_W   = $clog2(N_WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        thresh_we_i,
  input  logic [POT_W-1:0]            thresh_i,
  input  logic [REFR_W-1:0]           refr_len_i,
  input  logic [1:0]                  mode_i,
  input  logic                        start_i,
  input  logic                        pix_valid_i,
  input  logic [WORD_W-1:0]           pix_i,
  input  logic [N_NEURONS*WORD_W-1:0] weight_i,
  input  logic [WORD_W-1:0]           late_i,
  output logic                        busy_o,
  output logic [WIDX_W-1:0]           word_idx_o,
  output logic                        spike_valid_o,
  output logic [NIDX_W-1:0]           winner_o,
  output logic                        upd_valid_o,
  output logic [WORD_W-1:0]           upd_pot_o,
  output logic [WORD_W-1:0]           upd_dep_o
);
  step_state_e state_q;
  logic [WIDX_W-1:0] wrd_q;
  logic [POT_W-1:0]  thr_q;
  logic [N_NEURONS-1:0][POT_W-1:0] pot;
  logic [N_NEURONS-1:0] elig;
  logic win_valid;
  logic [NIDX_W-1:0] win_idx;
  logic acc_en, step_done, last_word;

  assign acc_en      = (state_q == ST_INTEG) && pix_valid_i;
  assign step_done   = (state_q == ST_DECIDE);
  assign last_word   = (wrd_q == WIDX_W'(N_WORDS - 1));
  assign busy_o      = (state_q != ST_IDLE);
  assign word_idx_o  = wrd_q;
  assign upd_valid_o = (state_q == ST_LEARN) && pix_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      wrd_q         <= '0;
      thr_q         <= '0;
      spike_valid_o <= 1'b0;
      winner_o      <= '0;
    end else begin
      spike_valid_o <= step_done && win_valid;
      case (state_q)
        ST_IDLE: begin
          if (thresh_we_i) thr_q <= thresh_i;
          wrd_q <= '0;
          if (start_i) state_q <= ST_INTEG;
        end
        ST_INTEG, ST_LEARN: if (pix_valid_i) begin
          wrd_q <= last_word ? '0 : wrd_q + WIDX_W'(1);
          if (last_word) state_q <= (state_q == ST_INTEG) ? ST_DECIDE : ST_IDLE;
        end
        default: begin
          wrd_q <= '0;
          if (win_valid) begin
            winner_o <= win_idx;
            state_q  <= ST_LEARN;
          end else begin
            state_q  <= ST_IDLE;
          end
        end
      endcase
    end
  end

  for (genvar k = 0; k < N_NEURONS; k++) begin : g_neuron
    wta_neuron #(.WORD_W(WORD_W), .POT_W(POT_W), .REFR_W(REFR_W)) u_neuron (
      .clk_i, .rst_ni,
      .acc_en_i   (acc_en),
      .clr_i      (step_done && win_valid),
      .fire_i     (step_done && win_valid && win_idx == NIDX_W'(k)),
      .step_done_i(step_done),
      .refr_len_i,
      .pix_i,
      .w_i        (weight_i[k*WORD_W +: WORD_W]),
      .pot_o      (pot[k]),
      .elig_o     (elig[k])
    );
  end

  wta_arbiter #(.N_NEURONS(N_NEURONS), .POT_W(POT_W)) u_arb (
    .pot_i(pot), .elig_i(elig), .thr_i(thr_q),
    .valid_o(win_valid), .idx_o(win_idx)
  );

  wta_learn_map #(.WORD_W(WORD_W)) u_map (
    .mode_i, .en_i(upd_valid_o), .pix_i, .late_i,
    .pot_o(upd_pot_o), .dep_o(upd_dep_o)
  );

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_valid_o |=> !spike_valid_o);
  a_r7_thr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(thr_q));
  a_r6_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_done && win_valid) |-> elig[win_idx]);
  a_r8_upd_in_learn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> busy_o && !spike_valid_o || $past(step_done));
  a_r5_clear_after_spike: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_valid_o |-> pot == '0);
endmodule

// File: tb/wta_if_layer_bench.sv
module wta_if_layer_bench;
  localparam int NN = 9, WW = 64, NW = 64, PW = 13;

  logic clk = 0, rst_n = 0;
  logic thr_we = 0, start = 0, pv = 0;
  logic [PW-1:0] thr = '0;
  logic [7:0] refr_len = '0;
  logic [1:0] mode = '0;
  logic [WW-1:0] pix = '0, late = '0;
  logic [NN*WW-1:0] weight = '0;
  logic busy, spk, updv;
  logic [5:0] widx;
  logic [3:0] win_o;
  logic [WW-1:0] upot, udep;

  int n_chk = 0, n_fail = 0;
  int wcnt [NN];
  logic [WW-1:0] pix_base = '1, late_base = '0;

  always #4 clk = ~clk;

  wta_if_layer u_wta_if_layer (
    .clk_i(clk), .rst_ni(rst_n), .thresh_we_i(thr_we), .thresh_i(thr),
    .refr_len_i(refr_len), .mode_i(mode), .start_i(start), .pix_valid_i(pv),
    .pix_i(pix), .weight_i(weight), .late_i(late), .busy_o(busy),
    .word_idx_o(widx), .spike_valid_o(spk), .winner_o(win_o),
    .upd_valid_o(updv), .upd_pot_o(upot), .upd_dep_o(udep));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] rot(input logic [WW-1:0] b, input int r);
    if (r == 0) return b;
    return (b << r) | (b >> (WW - r));
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; pv = 0; start = 0; thr_we = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic set_thr(input int v);
    @(negedge clk); thr_we = 1; thr = PW'(v);
    @(negedge clk); thr_we = 0;
  endtask

  task automatic load_weights();
    for (int k = 0; k < NN; k++)
      weight[k*WW +: WW] = (wcnt[k] >= WW) ? '1 : ((64'd1 << wcnt[k]) - 64'd1);
  endtask

  // one evaluation step; learning pass checked against mode rules
  task automatic do_step(output bit fired, output int win, input bit busy_write = 0);
    logic [WW-1:0] ep, ed;
    load_weights();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int w = 0; w < NW; w++) begin
      pv = 1; pix = rot(pix_base, w);
      if (w == 0 || w == NW - 1) chk("R2 word index", widx, w);
      if (busy_write && w == 5) begin thr_we = 1; thr = '1; end
      else thr_we = 0;
      @(negedge clk);
    end
    pv = 0; thr_we = 0;
    chk("R3 no early spike", spk, 0);
    @(negedge clk);
    fired = spk; win = int'(win_o);
    if (fired) begin
      for (int w = 0; w < NW; w++) begin
        pv = 1; pix = rot(pix_base, w); late = late_base;
        #1;
        case (mode)
          2'd0: begin ep = pix; ed = '0; end
          2'd1: begin ep = '0; ed = pix; end
          2'd2: begin ep = pix & ~late; ed = pix & late; end
          default: begin ep = pix & late; ed = pix & ~late; end
        endcase
        if (w == 1) chk("R3 pulse one cycle", spk, 0);
        if (w == 0 || w == 17 || w == NW - 1) begin
          chk("R8 upd valid", updv, 1);
          chk("R8 pot mask", upot, ep);
          chk("R8 dep mask", udep, ed);
        end
        @(negedge clk);
      end
      pv = 0; #1;
      chk("R8 idle after learn", busy, 0);
    end else begin
      #1;
      chk("R9 idle after no spike", busy, 0);
      chk("R9 no update", updv, 0);
    end
  endtask

  task automatic clear_w();
    for (int k = 0; k < NN; k++) wcnt[k] = 0;
    pix_base = '1; late_base = '0; mode = 0; refr_len = 0;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    chk("R1 busy", busy, 0); chk("R1 spike", spk, 0);
    chk("R1 upd", updv, 0); chk("R1 widx", widx, 0);
  endtask

  task automatic t_basic();
    bit f; int w;
    do_reset(); clear_w(); set_thr(100);
    wcnt[1] = 1; wcnt[2] = 2; wcnt[3] = 3;
    do_step(f, w);
    chk("R3 fired", f, 1); chk("R4 highest wins", w, 3);
  endtask

  task automatic t_tie();
    bit f; int w;
    do_reset(); clear_w(); set_thr(100);
    wcnt[0] = 4; wcnt[2] = 5; wcnt[5] = 5; wcnt[8] = 3;
    do_step(f, w);
    chk("R4 tie fired", f, 1); chk("R4 tie lowest index", w, 2);
  endtask

  task automatic t_carry_clear();
    bit f; int w;
    do_reset(); clear_w(); set_thr(1000);
    wcnt[0] = 10;                 // 640 per step
    do_step(f, w); chk("R9 below threshold", f, 0);
    do_step(f, w); chk("R2 carry over fires", f, 1); chk("R2 carry winner", w, 0);
    do_step(f, w); chk("R5 cleared after spike", f, 0);
  endtask

  task automatic t_refr();
    bit f; int w;
    do_reset(); clear_w(); set_thr(100); refr_len = 2;
    wcnt[0] = 10; wcnt[1] = 5;
    do_step(f, w); chk("R6 step1 winner", w, 0);
    do_step(f, w); chk("R6 step2 fired", f, 1); chk("R6 step2 other wins", w, 1);
    do_step(f, w); chk("R6 step3 all refractory", f, 0);
    do_step(f, w); chk("R6 step4 fired", f, 1); chk("R6 step4 back", w, 0);
  endtask

  task automatic t_thr_busy();
    bit f; int w;
    do_reset(); clear_w(); set_thr(100);
    wcnt[6] = 2;                  // 128
    do_step(f, w, 1);
    chk("R7 write ignored while busy", f, 1); chk("R7 winner", w, 6);
  endtask

  task automatic t_modes();
    bit f; int w;
    do_reset(); clear_w(); set_thr(100);
    wcnt[4] = 64;
    pix_base = 64'h00FF_3C5A_F0F0_1234; late_base = 64'h0F0F_3333_0000_FFFF;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      do_step(f, w);
      chk("R8 mode step fired", f, 1); chk("R8 winner", w, 4);
    end
  endtask

  task automatic t_sat();
    bit f; int w;
    do_reset(); clear_w(); set_thr(8191);
    wcnt[0] = 64; wcnt[1] = 63;
    do_step(f, w); chk("R10 4096 below max", f, 0);
    do_step(f, w); chk("R10 saturates and fires", f, 1); chk("R10 winner", w, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_tie();
    t_carry_clear();
    t_refr();
    t_thr_busy();
    t_modes();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule